// File: doc/BRIEF.md
# Sample-Number Stream Aligner

The block takes two streams of complex 16-bit words, one from a master receiver and one from a slave receiver. Each stream is split into frames of `NCH` complex words. The first word of a frame carries a 32-bit sample number, with the high half in I and the low half in Q. The words after it carry the data channels. The two receivers run off a shared clock, but they may start at different sample numbers, so their streams can be offset from one another.

Each side is collected into a frame register. Once both sides hold a complete frame, the two sample numbers are compared. If they differ, the whole frame on the lagging side is discarded. If they match, both frames go out together, one word per transfer, in their original order. An `aligned` status output reports whether the most recent decision was a match. All four stream edges use a valid/ready handshake.

Top module: `stream_aligner`

## Requirements
- R1: A frame is `NCH` consecutive accepted input words, with `NCH` at least 2. Word 0 holds the sample number, with I as bits 31..16 and Q as bits 15..0. Frame boundaries on each side follow only from the count of accepted words since reset.
- R2: When both sides hold a complete frame and the sample numbers differ, the lagging frame is discarded and no output word is presented. The lagging side is the master when (master − slave) mod 2^32, read as a signed value, is negative, and the slave otherwise.
- R3: The lag decision holds across wraparound. A master frame numbered 0xFFFFFFFE is behind a slave frame numbered 0x00000001, and it is the master frame that gets discarded.
- R4: When both sample numbers are equal, both frames are emitted word by word: the counter word first, then the data words in input order, with I and Q unchanged. Every matched pair is emitted once.
- R5: An output word moves only when both output readies are high. Each side's output valid is low whenever the other side's ready is low. The master and slave outputs therefore always transfer in the same cycle.
- R6: `aligned` is 0 until a matched pair has been found, and it is 1 from the cycle after a match is first presented. It returns to 0 in the cycle after a frame is discarded.
- R7: An active-low synchronous reset clears `aligned`, any partially or fully collected frame, and the output position. After reset both input readies are 1 and both output valids are 0.
- R8: A side's input ready is 0 while that side holds a complete frame, including every cycle in which that frame is being emitted. Input words are accepted strictly in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mst_in_valid | input | 1 | Master input word valid |
| mst_in_ready | output | 1 | Master input word accepted |
| mst_in_i | input | W | Master input I half |
| mst_in_q | input | W | Master input Q half |
| slv_in_valid | input | 1 | Slave input word valid |
| slv_in_ready | output | 1 | Slave input word accepted |
| slv_in_i | input | W | Slave input I half |
| slv_in_q | input | W | Slave input Q half |
| mst_out_valid | output | 1 | Master aligned word valid |
| mst_out_ready | input | 1 | Master downstream ready |
| mst_out_i | output | W | Master aligned I half |
| mst_out_q | output | W | Master aligned Q half |
| slv_out_valid | output | 1 | Slave aligned word valid |
| slv_out_ready | input | 1 | Slave downstream ready |
| slv_out_i | output | W | Slave aligned I half |
| slv_out_q | output | W | Slave aligned Q half |
| aligned | output | 1 | Most recent frame decision was a match |

## Verification
The bench builds the block with `W` = 16 and `NCH` = 3: a counter word plus two data channels. With three words per frame there is a middle word, so a slip within a frame would show up. The last word of a frame also lands at least two cycles after the match decision, which makes the `aligned` timing observable at the ports. Counter offsets are applied on either side, along with a start just below 2^32 and a gap in the slave's numbering partway through a run. Together these reach master drops, slave drops, a wraparound drop and a loss of alignment after a lock. A reset placed in the middle of a frame, and sparse random readies, cover frame restart and the joint output handshake.

// File: rtl/salign_pkg.sv
// Package: shared types and the counter lag function for the stream aligner.
// Assumes the embedded sample number is exactly 32 bits wide.
package salign_pkg;

    localparam int CNT_W = 32;

    // Outcome of comparing the two held frames.
    typedef enum logic [1:0] {
        DEC_WAIT   = 2'd0,
        DEC_EMIT   = 2'd1,
        DEC_DROP_M = 2'd2,
        DEC_DROP_S = 2'd3
    } dec_e;

    // Signed modulo-2^32 distance of a ahead of b.
    function automatic logic signed [CNT_W-1:0] lag_of(input logic [CNT_W-1:0] a,
                                                      input logic [CNT_W-1:0] b);
        return signed'(a - b);
    endfunction

endpackage

// File: rtl/frame_collect.sv
// Module: frame_collect
// Gathers NCH input words into a frame register. It then refuses further
// input until the controller releases the frame, either after emitting it
// or by discarding it. Assumes NCH >= 2 and that release only arrives while
// the frame is full.
module frame_collect #(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [W-1:0]              in_i,
    input  logic [W-1:0]              in_q,
    input  logic                      release_i,
    output logic                      full_o,
    output logic [NCH-1:0][2*W-1:0]   frame_o
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCH - 1);

    logic [IDX_W-1:0]            idx_q;
    logic                        full_q;
    logic                        take;
    logic [NCH-1:0][2*W-1:0]     frame_q;

    assign in_ready = !full_q;
    assign take     = in_valid && !full_q;
    assign full_o   = full_q;
    assign frame_o  = frame_q;

    // Word position and frame-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (full_q) begin
            if (release_i) begin
                full_q <= 1'b0;
                idx_q  <= '0;
            end
        end else if (take) begin
            if (idx_q == LAST) begin
                full_q <= 1'b1;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // One storage slot per word position.
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        // Capture the accepted word into its slot.
        always_ff @(posedge clk) begin
            if (take && (idx_q == IDX_W'(g))) begin
                frame_q[g] <= {in_i, in_q};
            end
        end
    end

endmodule

// File: rtl/align_ctrl.sv
// Module: align_ctrl
// Compares the two held sample numbers, discards the lagging frame or
// steps through a matched pair one word per joint transfer, and keeps the
// aligned flag. Assumes both full inputs come from frame_collect instances.
module align_ctrl
    import salign_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          m_full,
    input  logic                          s_full,
    input  logic [CNT_W-1:0]              m_cnt,
    input  logic [CNT_W-1:0]              s_cnt,
    input  logic                          m_out_ready,
    input  logic                          s_out_ready,
    output logic                          m_out_valid,
    output logic                          s_out_valid,
    output logic                          m_release,
    output logic                          s_release,
    output logic [$clog2(NCH)-1:0]        word_idx,
    output logic                          aligned_o,
    output dec_e                          dec_o
);
    localparam int IDX_W = $clog2(NCH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCH - 1);

    dec_e                    dec;
    logic signed [CNT_W-1:0] lag;
    logic                    xfer;
    logic                    last_word;
    logic [IDX_W-1:0]        idx_q;
    logic                    aligned_q;

    assign lag = lag_of(m_cnt, s_cnt);

    // Choose between waiting, emitting and discarding one side.
    always_comb begin
        if (!(m_full && s_full))  dec = DEC_WAIT;
        else if (lag == '0)       dec = DEC_EMIT;
        else if (lag < 0)         dec = DEC_DROP_M;
        else                      dec = DEC_DROP_S;
    end

    assign xfer        = (dec == DEC_EMIT) && m_out_ready && s_out_ready;
    assign last_word   = (idx_q == LAST);
    assign m_out_valid = (dec == DEC_EMIT) && s_out_ready;
    assign s_out_valid = (dec == DEC_EMIT) && m_out_ready;
    assign m_release   = (dec == DEC_DROP_M) || (xfer && last_word);
    assign s_release   = (dec == DEC_DROP_S) || (xfer && last_word);
    assign word_idx    = idx_q;
    assign aligned_o   = aligned_q;
    assign dec_o       = dec;

    // Output word position within the matched pair.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (xfer)       idx_q <= last_word ? '0 : idx_q + 1'b1;
    end

    // Aligned status: set on a match, cleared on a discard.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          aligned_q <= 1'b0;
        else if (dec == DEC_EMIT)                            aligned_q <= 1'b1;
        else if (dec == DEC_DROP_M || dec == DEC_DROP_S)     aligned_q <= 1'b0;
    end

endmodule

// File: rtl/stream_aligner.sv
// Module: stream_aligner (top)
// Aligns a master and a slave stream of complex words by the sample number
// carried in word 0 of every frame. The lagging side's frames are discarded
// until the numbers agree, then matched pairs go out in lock-step.
// Assumes W = 16 (a 32-bit counter split over I and Q) and NCH >= 2.
module stream_aligner
    import salign_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mst_in_valid,
    output logic          mst_in_ready,
    input  logic [W-1:0]  mst_in_i,
    input  logic [W-1:0]  mst_in_q,
    input  logic          slv_in_valid,
    output logic          slv_in_ready,
    input  logic [W-1:0]  slv_in_i,
    input  logic [W-1:0]  slv_in_q,
    output logic          mst_out_valid,
    input  logic          mst_out_ready,
    output logic [W-1:0]  mst_out_i,
    output logic [W-1:0]  mst_out_q,
    output logic          slv_out_valid,
    input  logic          slv_out_ready,
    output logic [W-1:0]  slv_out_i,
    output logic [W-1:0]  slv_out_q,
    output logic          aligned
);
    localparam int IDX_W = $clog2(NCH);

    logic                      m_full, s_full, m_rel, s_rel;
    logic [NCH-1:0][2*W-1:0]   m_frame, s_frame;
    logic [IDX_W-1:0]          word_idx;
    dec_e                      dec;

    frame_collect #(.W(W), .NCH(NCH)) u_mcol (
        .clk(clk), .rst_n(rst_n),
        .in_valid(mst_in_valid), .in_ready(mst_in_ready),
        .in_i(mst_in_i), .in_q(mst_in_q),
        .release_i(m_rel), .full_o(m_full), .frame_o(m_frame)
    );

    frame_collect #(.W(W), .NCH(NCH)) u_scol (
        .clk(clk), .rst_n(rst_n),
        .in_valid(slv_in_valid), .in_ready(slv_in_ready),
        .in_i(slv_in_i), .in_q(slv_in_q),
        .release_i(s_rel), .full_o(s_full), .frame_o(s_frame)
    );

    align_ctrl #(.NCH(NCH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .m_full(m_full), .s_full(s_full),
        .m_cnt(CNT_W'(m_frame[0])), .s_cnt(CNT_W'(s_frame[0])),
        .m_out_ready(mst_out_ready), .s_out_ready(slv_out_ready),
        .m_out_valid(mst_out_valid), .s_out_valid(slv_out_valid),
        .m_release(m_rel), .s_release(s_rel),
        .word_idx(word_idx), .aligned_o(aligned), .dec_o(dec)
    );

    // Present the current word of each held frame.
    always_comb begin
        {mst_out_i, mst_out_q} = m_frame[word_idx];
        {slv_out_i, slv_out_q} = s_frame[word_idx];
    end

endmodule

// File: rtl/stream_aligner_chk.sv
// Module: stream_aligner_chk
// Property checker bound into stream_aligner. It watches the port handshakes
// and the controller's decision. Assumes the same parameters as the design.
module stream_aligner_chk
    import salign_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mst_in_ready,
    input logic          slv_in_ready,
    input logic          mst_out_valid,
    input logic          mst_out_ready,
    input logic          slv_out_valid,
    input logic          slv_out_ready,
    input logic [W-1:0]  mst_out_i,
    input logic [W-1:0]  mst_out_q,
    input logic [W-1:0]  slv_out_i,
    input logic [W-1:0]  slv_out_q,
    input logic [$clog2(NCH)-1:0] word_idx,
    input dec_e          dec,
    input logic          aligned
);
    // R5: the two outputs transfer together
    a_r5_joint_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_out_valid && mst_out_ready) == (slv_out_valid && slv_out_ready));

    // R8: a side being emitted accepts no input
    a_r8_hold_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_out_valid || slv_out_valid) |-> (!mst_in_ready && !slv_in_ready));

    // R2: nothing is presented during a discard
    a_r2_quiet_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_DROP_M || dec == DEC_DROP_S) |-> (!mst_out_valid && !slv_out_valid));

    // R4: the counter words of a presented pair are equal
    a_r4_counter_match: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_out_valid && word_idx == '0) |-> (mst_out_i == slv_out_i && mst_out_q == slv_out_q));

    // R6: aligned rises only after a match decision
    a_r6_rise_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(dec == DEC_EMIT));

    // R6: aligned falls only after a discard
    a_r6_fall_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aligned) |-> $past(dec == DEC_DROP_M || dec == DEC_DROP_S));

endmodule

bind stream_aligner stream_aligner_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mst_in_ready(mst_in_ready), .slv_in_ready(slv_in_ready),
    .mst_out_valid(mst_out_valid), .mst_out_ready(mst_out_ready),
    .slv_out_valid(slv_out_valid), .slv_out_ready(slv_out_ready),
    .mst_out_i(mst_out_i), .mst_out_q(mst_out_q),
    .slv_out_i(slv_out_i), .slv_out_q(slv_out_q),
    .word_idx(word_idx), .dec(dec), .aligned(aligned)
);

// File: tb/sim_stream_aligner.sv
// Bench: a queue-based reference model of drop-until-match alignment,
// compared against the outputs on every clock.
module sim_stream_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mi_valid = 1'b0, si_valid = 1'b0;
    logic mi_ready, si_ready;
    logic [W-1:0] mi_i = '0, mi_q = '0, si_i = '0, si_q = '0;
    logic mo_valid, so_valid;
    logic mo_ready = 1'b0, so_ready = 1'b0;
    logic [W-1:0] mo_i, mo_q, so_i, so_q;
    logic aligned;

    int checks = 0, fails = 0;
    int rdy_pct = 100;
    bit mon_en = 1'b0;
    int matched = 0;
    int out_pos = 0;
    bit saw_fall = 1'b0;
    logic prev_aligned = 1'b0;
    logic [31:0] mq[$], sq[$], em[$], es[$];

    stream_aligner #(.W(W), .NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .mst_in_valid(mi_valid), .mst_in_ready(mi_ready), .mst_in_i(mi_i), .mst_in_q(mi_q),
        .slv_in_valid(si_valid), .slv_in_ready(si_ready), .slv_in_i(si_i), .slv_in_q(si_q),
        .mst_out_valid(mo_valid), .mst_out_ready(mo_ready), .mst_out_i(mo_i), .mst_out_q(mo_q),
        .slv_out_valid(so_valid), .slv_out_ready(so_ready), .slv_out_i(so_i), .slv_out_q(so_q),
        .aligned(aligned)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Downstream ready generator.
    initial begin
        forever begin
            @(posedge clk); #1;
            mo_ready = ($urandom_range(0, 99) < rdy_pct);
            so_ready = ($urandom_range(0, 99) < rdy_pct);
        end
    end

    // Monitor and reference model, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (mo_valid && !so_ready) chk(1'b0, "R5 valid without partner ready", 32'(mo_valid), 32'd0);
            if (so_valid && !mo_ready) chk(1'b0, "R5 valid without partner ready", 32'(so_valid), 32'd0);
            if ((mo_valid && mo_ready) != (so_valid && so_ready))
                chk(1'b0, "R5 joint transfer", 32'(mo_valid && mo_ready), 32'(so_valid && so_ready));
            if (aligned && matched == 0) chk(1'b0, "R6 aligned before any match", 32'(aligned), 32'd0);
            if (prev_aligned && !aligned) saw_fall = 1'b1;
            prev_aligned = aligned;
            if (mo_valid && mo_ready && so_valid && so_ready) begin
                if (em.size() == 0) chk(1'b0, "R4 unexpected output word", {mo_i, mo_q}, 32'hx);
                else begin
                    logic [31:0] xm, xs;
                    xm = em.pop_front();
                    xs = es.pop_front();
                    chk({mo_i, mo_q} == xm, "R4 master word", {mo_i, mo_q}, xm);
                    chk({so_i, so_q} == xs, "R4 slave word", {so_i, so_q}, xs);
                    chk(!mi_ready && !si_ready, "R8 input held while emitting", {30'd0, mi_ready, si_ready}, 32'd0);
                    if (out_pos == NCH - 1) chk(aligned == 1'b1, "R6 aligned during matched pair", 32'(aligned), 32'd1);
                end
                out_pos = (out_pos == NCH - 1) ? 0 : out_pos + 1;
            end
            if (mi_valid && mi_ready) mq.push_back({mi_i, mi_q});
            if (si_valid && si_ready) sq.push_back({si_i, si_q});
            while (mq.size() >= NCH && sq.size() >= NCH) begin
                logic signed [31:0] d;
                d = signed'(mq[0] - sq[0]);
                if (d < 0)      repeat (NCH) void'(mq.pop_front());
                else if (d > 0) repeat (NCH) void'(sq.pop_front());
                else begin
                    repeat (NCH) begin
                        em.push_back(mq.pop_front());
                        es.push_back(sq.pop_front());
                    end
                    matched++;
                end
            end
        end
    end

    task automatic do_reset();
        mon_en = 1'b0;
        rst_n = 1'b0;
        mi_valid = 1'b0;
        si_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        mq.delete(); sq.delete(); em.delete(); es.delete();
        matched = 0; out_pos = 0; saw_fall = 1'b0; prev_aligned = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(mi_ready && si_ready, "R7 input ready after reset", {30'd0, mi_ready, si_ready}, 32'd3);
        chk(!mo_valid && !so_valid, "R7 output valid after reset", {30'd0, mo_valid, so_valid}, 32'd0);
        chk(!aligned, "R7 aligned after reset", 32'(aligned), 32'd0);
        mon_en = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic drive_side(input bit is_m, input logic [31:0] start, input int nf, input int skip_at);
        for (int f = 0; f < nf; f++) begin
            logic [31:0] c;
            c = start + 32'(f) + ((f >= skip_at) ? 32'd1 : 32'd0);
            for (int w = 0; w < NCH; w++) begin
                logic [31:0] word;
                bit acc;
                word = (w == 0) ? c : $urandom;
                while ($urandom_range(0, 3) == 0) begin
                    @(posedge clk); #1;
                end
                if (is_m) begin mi_valid = 1'b1; {mi_i, mi_q} = word; end
                else      begin si_valid = 1'b1; {si_i, si_q} = word; end
                do begin
                    @(negedge clk);
                    acc = is_m ? (mi_valid && mi_ready) : (si_valid && si_ready);
                    @(posedge clk); #1;
                end while (!acc);
                if (is_m) mi_valid = 1'b0; else si_valid = 1'b0;
            end
        end
    endtask

    task automatic run_phase(input string name, input logic [31:0] ms, input int mn,
                             input logic [31:0] ss, input int sn, input int s_skip, input int pct);
        rdy_pct = pct;
        fork
            drive_side(1'b1, ms, mn, 1 << 30);
            drive_side(1'b0, ss, sn, s_skip);
        join
        rdy_pct = 100;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(em.size() == 0, {"R4 all matched words emitted ", name}, 32'(em.size()), 32'd0);
        chk(aligned == 1'b1, {"R6 aligned at end ", name}, 32'(aligned), 32'd1);
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        // R2: slave behind by three frames
        do_reset();
        run_phase("slave lag", 32'd100, 10, 32'd97, 13, 1 << 30, 70);
        chk(matched == 10, "R2 matched count slave lag", 32'(matched), 32'd10);

        // R2: master behind by five frames
        do_reset();
        run_phase("master lag", 32'd50, 15, 32'd55, 10, 1 << 30, 70);
        chk(matched == 10, "R2 matched count master lag", 32'(matched), 32'd10);

        // R3: wraparound, master at 0xFFFFFFFE is behind slave at 1
        do_reset();
        run_phase("wrap", 32'hFFFF_FFFE, 13, 32'd1, 10, 1 << 30, 70);
        chk(matched == 10, "R3 matched count across wrap", 32'(matched), 32'd10);

        // R6: slave numbering gap after lock, alignment lost then regained
        do_reset();
        run_phase("gap", 32'd200, 12, 32'd200, 11, 5, 80);
        chk(saw_fall == 1'b1, "R6 aligned cleared on later mismatch", 32'(saw_fall), 32'd1);
        chk(matched == 11, "R6 matched count with gap", 32'(matched), 32'd11);

        // R7/R1: reset mid-frame, then framing must restart at word 0
        do_reset();
        mi_valid = 1'b1; {mi_i, mi_q} = 32'h1234_5678;
        @(posedge clk); #1;
        mi_valid = 1'b0;
        do_reset();
        // R5: sparse downstream readies
        run_phase("sparse ready", 32'd7, 10, 32'd7, 10, 1 << 30, 30);
        chk(matched == 10, "R1 framing after mid-frame reset", 32'(matched), 32'd10);

        finish_run();
    end

endmodule